// File: doc/BRIEF.md
# Decimal and ASCII Adjust Unit

This unit corrects byte results after binary arithmetic so they become packed decimal (two digits per byte) or unpacked decimal (one digit per byte). It works on a low result byte and a high result byte, along with the incoming carry and half-carry (auxiliary) flags. It returns the corrected bytes, the carry and half-carry flags, and sign, zero and parity flags taken from the final low byte.

There are six operations. Two correct packed decimal after an add or a subtract. Two correct unpacked decimal after an add or a subtract, and these move a digit carry or borrow into the high byte. The last two convert between two unpacked digits and a binary value in an arbitrary base. One folds the digits into a binary value with a shift-add multiplier. The other splits a binary value into two digits with a restoring divider, and it raises a divide-error request when the base is zero.

A caller presents its operands with a one-cycle start pulse. It then waits for the one-cycle done pulse, which arrives after a fixed latency per operation. The results stay on the outputs until the next completion.

Top module: `bcd_adjust_unit`

## Requirements
- R1: While rst_n is low at a clock edge, done, div_err and every data and flag output are cleared to 0.
- R2: op=0 (packed add fix). Let L be true when the low nibble of lo_in is above 9 or af_in is 1. When L is true, lo becomes lo+6 and carry becomes cf_in OR the carry out of that add; otherwise lo and carry are unchanged. af_out equals L. Then, if the high nibble of that lo is above 9 or the carry is 1, lo gains 0x60 (mod 256) and cf_out is 1; otherwise cf_out is 0. hi_out equals hi_in.
- R3: op=1 (packed subtract fix) works like R2, but it subtracts 6 and 0x60, and the borrow out of the first subtract is ORed into the carry.
- R4: op=2 (unpacked add fix). When L holds, lo_out=(lo_in+6)&0x0F, hi_out=hi_in+1, and cf_out=af_out=1. Otherwise lo_out=lo_in&0x0F, hi_out=hi_in, and both flags are 0.
- R5: op=3 (unpacked subtract fix) works like R4, but it uses lo_in-6 and hi_in-1.
- R6: op=4 (digits to binary) gives lo_out=(lo_in+hi_in*base_in) mod 256, hi_out=0 and cf_out=af_out=0.
- R7: op=5 (binary to digits) with a nonzero base gives hi_out=lo_in/base_in, lo_out=lo_in mod base_in and cf_out=af_out=0.
- R8: op=5 with base_in=0 raises div_err together with done, for that one cycle only. In that case lo_out, hi_out, cf_out and af_out equal their inputs.
- R9: done goes high exactly N clock edges after the edge that accepts start. N is 4 for op 0, 1, 6 and 7, 8 for op 2 and 3, 60 for op 4, and 83 for op 5.
- R10: At each completion, sf_out is bit 7 of lo_out, zf_out is 1 exactly when lo_out is 0, and pf_out is 1 when lo_out has an even number of set bits.
- R11: A start that arrives while an operation is in progress is ignored. The running operation keeps its latency and its result.
- R12: done is high for one cycle per operation. All result outputs hold their values between completions.
- R13: op=6 and op=7 are no-ops. lo, hi, cf and af pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (taken when idle) |
| op | input | 3 | Operation select, see R2-R7, R13 |
| lo_in | input | 8 | Low result byte |
| hi_in | input | 8 | High result byte |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming half-carry flag |
| base_in | input | 8 | Number base for op 4 and 5 |
| done | output | 1 | One-cycle completion pulse |
| lo_out | output | 8 | Corrected low byte |
| hi_out | output | 8 | Corrected high byte |
| cf_out | output | 1 | Carry flag out |
| af_out | output | 1 | Half-carry flag out |
| sf_out | output | 1 | Sign of lo_out |
| zf_out | output | 1 | lo_out is zero |
| pf_out | output | 1 | lo_out has even parity |
| div_err | output | 1 | Divide-error request (zero base) |

## Verification
Two events can fall in the same cycle: the completion of one operation and the start of the next. A start held during the cycle in which done is high must be accepted. A start sampled while the unit is still working must be dropped, including one in its last busy cycle. The bench issues operations back to back by raising start in the done cycle, and it also injects a stray start in the middle of a long operation. In both cases it judges the outcome by the next result and by the number of edges counted to done.

// File: rtl/bcd_adj_pkg.sv
// Shared types for the decimal/ASCII adjust unit.
// Assumes byte-wide operands; nibble rules depend on DW being 8.
package bcd_adj_pkg;
    localparam int DW = 8;

    typedef enum logic [2:0] {
        OP_PK_ADD = 3'd0,
        OP_PK_SUB = 3'd1,
        OP_UN_ADD = 3'd2,
        OP_UN_SUB = 3'd3,
        OP_TO_BIN = 3'd4,
        OP_TO_DIG = 3'd5,
        OP_NOP6   = 3'd6,
        OP_NOP7   = 3'd7
    } adj_op_e;

    typedef struct packed {
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        logic          cf;
        logic          af;
    } adj_res_t;
endpackage

// File: rtl/bcd_nibble_fix.sv
// Combinational nibble correction for the four add/subtract fix-ups.
// Assumes operands are stable for the whole operation (registered upstream).
// Any other op code passes the operands through unchanged.
module bcd_nibble_fix
    import bcd_adj_pkg::*;
(
    input  adj_op_e       op,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    input  logic          cf,
    input  logic          af,
    output adj_res_t      res
);
    logic          low_big;
    logic [DW:0]   stage1;
    logic          c1;
    logic [DW-1:0] s1;

    // Two-stage correction per operation.
    always_comb begin
        low_big = (lo[3:0] > 4'd9) || af;
        stage1  = {1'b0, lo};
        c1      = cf;
        s1      = lo;
        res     = '{lo: lo, hi: hi, cf: cf, af: af};
        case (op)
            OP_PK_ADD, OP_PK_SUB: begin
                if (op == OP_PK_ADD)
                    stage1 = {1'b0, lo} + (low_big ? 9'd6 : 9'd0);
                else
                    stage1 = {1'b0, lo} - (low_big ? 9'd6 : 9'd0);
                s1     = stage1[DW-1:0];
                c1     = cf | (low_big & stage1[DW]);
                res.af = low_big;
                if ((s1[7:4] > 4'd9) || c1) begin
                    res.lo = (op == OP_PK_ADD) ? s1 + 8'h60 : s1 - 8'h60;
                    res.cf = 1'b1;
                end else begin
                    res.lo = s1;
                    res.cf = 1'b0;
                end
            end
            OP_UN_ADD, OP_UN_SUB: begin
                if (low_big) begin
                    s1     = (op == OP_UN_ADD) ? lo + 8'd6 : lo - 8'd6;
                    res.hi = (op == OP_UN_ADD) ? hi + 8'd1 : hi - 8'd1;
                end
                res.lo = {4'h0, s1[3:0]};
                res.cf = low_big;
                res.af = low_big;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bcd_mac_engine.sv
// Sequential shift-add multiply-accumulate: acc = acc_in + mcand_in * mplier_in (mod 2^W).
// Takes W cycles after load; result is stable once the step count reaches zero.
module bcd_mac_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] mcand_in,
    input  logic [W-1:0] mplier_in,
    output logic [W-1:0] result
);
    localparam int SW = $clog2(W + 1);

    logic [W-1:0]  acc_q, mcand_q, mplier_q;
    logic [SW-1:0] steps_q;

    // Load operands, then add one shifted partial product per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            steps_q  <= '0;
        end else if (load) begin
            acc_q    <= acc_in;
            mcand_q  <= mcand_in;
            mplier_q <= mplier_in;
            steps_q  <= SW'(W);
        end else if (steps_q != '0) begin
            if (mplier_q[0])
                acc_q <= acc_q + mcand_q;
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
            steps_q  <= steps_q - 1'b1;
        end
    end

    assign result = acc_q;
endmodule

// File: rtl/bcd_div_engine.sv
// Sequential restoring divider, one quotient bit per cycle, W cycles after load.
// A zero divisor yields meaningless results; the caller must screen it.
module bcd_div_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int SW = $clog2(W + 1);

    logic [W:0]    rem_q;
    logic [W-1:0]  quo_q, dvs_q;
    logic [SW-1:0] steps_q;
    logic [W:0]    shifted;

    assign shifted = {rem_q[W-1:0], quo_q[W-1]};

    // Shift in the next dividend bit and subtract the divisor when it fits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            quo_q   <= '0;
            dvs_q   <= '0;
            steps_q <= '0;
        end else if (load) begin
            rem_q   <= '0;
            quo_q   <= dividend;
            dvs_q   <= divisor;
            steps_q <= SW'(W);
        end else if (steps_q != '0) begin
            if (shifted >= {1'b0, dvs_q}) begin
                rem_q <= shifted - {1'b0, dvs_q};
                quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
                rem_q <= shifted;
                quo_q <= {quo_q[W-2:0], 1'b0};
            end
            steps_q <= steps_q - 1'b1;
        end
    end

    assign quotient  = quo_q;
    assign remainder = rem_q[W-1:0];
endmodule

// File: rtl/bcd_adjust_unit.sv
// Decimal/ASCII adjust unit top. Latches operands on an accepted start,
// runs a fixed per-operation latency, then registers results and pulses done.
// Assumes the engines' W steps fit inside the base-conversion latencies.
module bcd_adjust_unit
    import bcd_adj_pkg::*;
#(
    parameter int LAT_PK  = 4,
    parameter int LAT_UN  = 8,
    parameter int LAT_BIN = 60,
    parameter int LAT_DIG = 83
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [7:0]   lo_in,
    input  logic [7:0]   hi_in,
    input  logic         cf_in,
    input  logic         af_in,
    input  logic [7:0]   base_in,
    output logic         done,
    output logic [7:0]   lo_out,
    output logic [7:0]   hi_out,
    output logic         cf_out,
    output logic         af_out,
    output logic         sf_out,
    output logic         zf_out,
    output logic         pf_out,
    output logic         div_err
);
    localparam int LAT_MAX = (LAT_DIG > LAT_BIN) ? LAT_DIG : LAT_BIN;
    localparam int CW      = $clog2(LAT_MAX + 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    adj_op_e       op_q;
    logic [DW-1:0] lo_q, hi_q, base_q;
    logic          cf_q, af_q;
    logic          accept, finish;
    adj_res_t      fix_res, fin_res;
    logic          fin_err;
    logic [DW-1:0] mac_res, quo, rem;

    assign accept = start && !busy_q;
    assign finish = busy_q && (cnt_q == '0);

    function automatic logic [CW-1:0] lat_of(adj_op_e o);
        case (o)
            OP_UN_ADD, OP_UN_SUB: return CW'(LAT_UN - 1);
            OP_TO_BIN:            return CW'(LAT_BIN - 1);
            OP_TO_DIG:            return CW'(LAT_DIG - 1);
            default:              return CW'(LAT_PK - 1);
        endcase
    endfunction

    bcd_nibble_fix u_fix (
        .op (op_q), .lo (lo_q), .hi (hi_q), .cf (cf_q), .af (af_q), .res (fix_res)
    );

    bcd_mac_engine #(.W(DW)) u_mac (
        .clk (clk), .rst_n (rst_n), .load (accept),
        .acc_in (lo_in), .mcand_in (hi_in), .mplier_in (base_in),
        .result (mac_res)
    );

    bcd_div_engine #(.W(DW)) u_div (
        .clk (clk), .rst_n (rst_n), .load (accept),
        .dividend (lo_in), .divisor (base_in),
        .quotient (quo), .remainder (rem)
    );

    // Sequencer: capture operands on accept, count down the latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_PK_ADD;
            lo_q   <= '0;
            hi_q   <= '0;
            base_q <= '0;
            cf_q   <= 1'b0;
            af_q   <= 1'b0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= lat_of(adj_op_e'(op));
            op_q   <= adj_op_e'(op);
            lo_q   <= lo_in;
            hi_q   <= hi_in;
            base_q <= base_in;
            cf_q   <= cf_in;
            af_q   <= af_in;
        end else if (finish) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Final result select across the three datapaths.
    always_comb begin
        fin_res = fix_res;
        fin_err = 1'b0;
        case (op_q)
            OP_TO_BIN: fin_res = '{lo: mac_res, hi: '0, cf: 1'b0, af: 1'b0};
            OP_TO_DIG: begin
                if (base_q == '0) begin
                    fin_res = '{lo: lo_q, hi: hi_q, cf: cf_q, af: af_q};
                    fin_err = 1'b1;
                end else begin
                    fin_res = '{lo: rem, hi: quo, cf: 1'b0, af: 1'b0};
                end
            end
            default: ;
        endcase
    end

    // Output registers: updated only at completion, done/div_err pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            div_err <= 1'b0;
            lo_out  <= '0;
            hi_out  <= '0;
            cf_out  <= 1'b0;
            af_out  <= 1'b0;
            sf_out  <= 1'b0;
            zf_out  <= 1'b0;
            pf_out  <= 1'b0;
        end else begin
            done    <= finish;
            div_err <= finish && fin_err;
            if (finish) begin
                lo_out <= fin_res.lo;
                hi_out <= fin_res.hi;
                cf_out <= fin_res.cf;
                af_out <= fin_res.af;
                sf_out <= fin_res.lo[DW-1];
                zf_out <= (fin_res.lo == '0);
                pf_out <= ~^fin_res.lo;
            end
        end
    end
endmodule

// File: rtl/bcd_adjust_checker.sv
// Temporal checks on the adjust unit, attached by bind.
module bcd_adjust_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy_q,
    input logic [2:0] op_q,
    input logic       done,
    input logic       div_err,
    input logic [7:0] lo_out,
    input logic [7:0] hi_out,
    input logic       cf_out,
    input logic       af_out,
    input logic       zf_out
);
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_outputs_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(lo_out) && $stable(hi_out) && $stable(cf_out) && $stable(af_out)));

    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> (done && op_q == 3'd5));

    assert_min_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_q) |=> !done);

    assert_ignore_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy_q) |=> (busy_q || done) && $stable(op_q));

    assert_to_bin_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == 3'd4) |-> (hi_out == 8'd0 && !cf_out && !af_out));

    assert_unpacked_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == 3'd2 || op_q == 3'd3)) |-> (cf_out == af_out && lo_out[7:4] == 4'h0));

    assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (zf_out == (lo_out == 8'd0)));
endmodule

bind bcd_adjust_unit bcd_adjust_checker u_chk (
    .clk (clk), .rst_n (rst_n), .start (start), .busy_q (busy_q),
    .op_q (op_q), .done (done), .div_err (div_err), .lo_out (lo_out),
    .hi_out (hi_out), .cf_out (cf_out), .af_out (af_out), .zf_out (zf_out)
);

// File: tb/bcd_adjust_unit_test.sv
module bcd_adjust_unit_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] op = '0;
    logic [7:0] lo_in = '0, hi_in = '0, base_in = '0;
    logic       cf_in = 1'b0, af_in = 1'b0;
    logic       done, cf_out, af_out, sf_out, zf_out, pf_out, div_err;
    logic [7:0] lo_out, hi_out;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bcd_adjust_unit uut (
        .clk (clk), .rst_n (rst_n), .start (start), .op (op),
        .lo_in (lo_in), .hi_in (hi_in), .cf_in (cf_in), .af_in (af_in),
        .base_in (base_in), .done (done), .lo_out (lo_out), .hi_out (hi_out),
        .cf_out (cf_out), .af_out (af_out), .sf_out (sf_out), .zf_out (zf_out),
        .pf_out (pf_out), .div_err (div_err)
    );

    typedef struct packed {
        logic [7:0] lo;
        logic [7:0] hi;
        logic cf, af, sf, zf, pf, err;
    } exp_t;

    function automatic exp_t model(int o, int lo, int hi, int c, int a, int b);
        exp_t e;
        int  x = lo, h = hi, cc = c, aa = a, er = 0;
        bit  big = ((lo & 15) > 9) || (a != 0);
        case (o)
            0, 1: begin
                if (big) begin
                    x = (o == 0) ? x + 6 : x - 6;
                    if (x > 255 || x < 0) cc = 1;
                    x = x & 255;
                end
                aa = big;
                if ((x >> 4) > 9 || cc != 0) begin
                    x  = ((o == 0) ? x + 'h60 : x - 'h60) & 255;
                    cc = 1;
                end else cc = 0;
            end
            2, 3: begin
                if (big) begin
                    x = ((o == 2) ? x + 6 : x - 6) & 15;
                    h = ((o == 2) ? h + 1 : h - 1) & 255;
                end else x = x & 15;
                cc = big; aa = big;
            end
            4: begin x = (lo + hi * b) & 255; h = 0; cc = 0; aa = 0; end
            5: begin
                if (b == 0) er = 1;
                else begin h = lo / b; x = lo % b; cc = 0; aa = 0; end
            end
            default: ;
        endcase
        e.lo = 8'(x); e.hi = 8'(h); e.cf = cc[0]; e.af = aa[0];
        e.sf = e.lo[7]; e.zf = (e.lo == 0); e.pf = ~^e.lo; e.err = er[0];
        return e;
    endfunction

    function automatic int lat(int o);
        case (o)
            2, 3: return 8;
            4: return 60;
            5: return 83;
            default: return 4;
        endcase
    endfunction

    function automatic string tag(int o, int b);
        case (o)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return (b == 0) ? "R8" : "R7";
            default: return "R13";
        endcase
    endfunction

    // Starts one operation at a negedge; returns at the negedge where done is seen.
    // stray_at > 0 raises a second start (different op) that many cycles in (R11).
    task automatic run_op(int o, int l, int h, int c, int a, int b, int stray_at);
        exp_t e = model(o, l, h, c, a, b);
        int   n = 0;
        op = 3'(o); lo_in = 8'(l); hi_in = 8'(h); cf_in = c[0]; af_in = a[0];
        base_in = 8'(b); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 200) begin
            if (stray_at > 0 && n == stray_at) begin
                start = 1'b1; op = 3'(~o); lo_in = ~lo_in;
            end
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
        end
        tests++;
        if (n != lat(o)) begin
            fails++;
            $display("FAIL R9 op=%0d latency actual=%0d expected=%0d", o, n, lat(o));
        end
        tests++;
        if ({lo_out, hi_out, cf_out, af_out, div_err} != {e.lo, e.hi, e.cf, e.af, e.err}) begin
            fails++;
            $display("FAIL %s op=%0d in=%h/%h c%0d a%0d b=%0d actual=%h/%h c%0d a%0d e%0d expected=%h/%h c%0d a%0d e%0d",
                     tag(o, b), o, l, h, c, a, b, lo_out, hi_out, cf_out, af_out, div_err,
                     e.lo, e.hi, e.cf, e.af, e.err);
        end
        tests++;
        if ({sf_out, zf_out, pf_out} != {e.sf, e.zf, e.pf}) begin
            fails++;
            $display("FAIL R10 op=%0d szp actual=%b%b%b expected=%b%b%b",
                     o, sf_out, zf_out, pf_out, e.sf, e.zf, e.pf);
        end
        if (stray_at > 0) begin
            tests++;
            if (n != lat(o)) begin
                fails++;
                $display("FAIL R11 stray start changed latency actual=%0d expected=%0d", n, lat(o));
            end
        end
    endtask

    // One idle cycle: done must drop and results hold (R12, R8 pulse).
    task automatic check_hold();
        logic [19:0] snap = {lo_out, hi_out, cf_out, af_out, sf_out, zf_out};
        @(posedge clk);
        @(negedge clk);
        tests++;
        if (done || div_err || {lo_out, hi_out, cf_out, af_out, sf_out, zf_out} != snap) begin
            fails++;
            $display("FAIL R12 hold actual=%b%b %h expected=00 %h", done, div_err,
                     {lo_out, hi_out, cf_out, af_out, sf_out, zf_out}, snap);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if ({done, div_err, lo_out, hi_out, cf_out, af_out, sf_out, zf_out, pf_out} != '0) begin
            fails++;
            $display("FAIL R1 reset actual=%h expected=0",
                     {done, div_err, lo_out, hi_out, cf_out, af_out, sf_out, zf_out, pf_out});
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners.
        run_op(0, 'h9A, 0, 0, 0, 0, 0); check_hold();   // R2 both stages
        run_op(0, 'h99, 0, 0, 0, 0, 0);                 // R2 no fix
        run_op(0, 'hFA, 0, 0, 0, 0, 0);                 // R2 carry merge
        run_op(1, 'h00, 0, 0, 1, 0, 0);                 // R3 borrow
        run_op(1, 'h45, 0, 1, 0, 0, 0);                 // R3 carry in
        run_op(2, 'h0F, 'hFF, 0, 0, 0, 0);              // R4 hi wrap
        run_op(2, 'h35, 'h01, 0, 0, 0, 0);              // R4 mask only
        run_op(3, 'h02, 'h00, 0, 1, 0, 0);              // R5 hi borrow
        run_op(4, 'h07, 'h03, 1, 1, 10, 0);             // R6 37
        run_op(4, 'hFF, 'hFF, 0, 0, 255, 0);            // R6 wrap
        run_op(5, 'h25, 'h77, 0, 0, 10, 0);             // R7
        run_op(5, 'hFF, 'h00, 0, 0, 1, 0);              // R7 base one
        run_op(5, 'h5A, 'h3C, 1, 0, 0, 0); check_hold(); // R8 zero base
        run_op(6, 'h80, 'h11, 1, 1, 0, 0);              // R13
        run_op(7, 'h00, 'h22, 0, 1, 0, 0);              // R13
        run_op(4, 'h01, 'h02, 0, 0, 3, 20);             // R11 stray start
        run_op(0, 'h3C, 0, 0, 0, 0, 3);                 // R11 stray in last busy cycle

        // Random mix, back to back or with an idle gap.
        for (int i = 0; i < 300; i++) begin
            int o = int'($urandom_range(0, 7));
            int b = ($urandom_range(0, 9) == 0) ? 0 : int'($urandom_range(0, 255));
            run_op(o, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                   int'($urandom_range(0, 1)), int'($urandom_range(0, 1)), b, 0);
            if (i % 2 == 1) check_hold();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule